// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. A frame lasts 13 clock periods. The first three periods sample the input and the remaining ten resolve it. During the resolving periods the block offers a trial word to an external DAC, one bit per period, starting with the most significant bit. It then keeps or clears that bit according to a single comparator bit. The finished code is latched when the next frame begins.

The frame can run continuously or on demand. Holding the active-low start request low runs frames back to back. If the request is high at the end of period 1, the sequencer waits in period 2 and keeps sampling. A start seen on a later edge moves it on to period 3. A ready flag tells the consumer that a new code is waiting. An active-low clear input can drop the flag at any time.

The comparator model belongs to the surrounding logic. It must drive `cmp_bit` high when the input is at or above the code on `dac_trial`.

Top module: `sar_conv_seq`

## Requirements
- R1: Periods are numbered 1 to 13. After reset the sequencer is in period 1. Each clock edge advances one period and period 13 wraps to 1, except for the wait described in R7. With `conv_start_n` held low, `result_ready` rises once every 13 cycles.
- R2: `track_en` is 1 during periods 1 to 3 and 0 during periods 4 to 13.
- R3: In period 4+k (k = 0..9), `dac_trial` holds the bits already decided above bit 9-k, with bit 9-k set to 1 and all lower bits at 0. At the edge ending that period, bit 9-k keeps its trial value of 1 if `cmp_bit` is 1 and becomes 0 otherwise. In periods 1 to 3, `dac_trial` is 0.
- R4: `conv_result` changes only at the edge that begins period 1. At that edge it takes the 10 decided bits, including the bit resolved on that same edge. Any code from 0x000 to 0x3FF can result.
- R5: `result_ready` becomes 1 at the edge that begins period 1, unless R10 applies.
- R6: If `conv_start_n` is 0 at the edge ending period 1, `result_ready` falls at that edge and the frame continues through period 2 without waiting.
- R7: If `conv_start_n` is 1 at the edge ending period 1, the sequencer stays in period 2 while `conv_start_n` stays 1. During the wait `track_en` remains 1 and `result_ready` stays 1.
- R8: While waiting in period 2, an edge that samples `conv_start_n` at 0 moves the sequencer to period 3 and clears `result_ready` at the same edge.
- R9: An edge that samples `rdy_clear_n` at 0 makes `result_ready` 0 after that edge, in any period.
- R10: If `rdy_clear_n` is 0 at the edge that begins period 1, `result_ready` stays 0 for that frame. `conv_result` is still updated.
- R11: `rst_n` low forces the reset state at once, with no clock needed. The reset state is period 1, `track_en` = 1, `result_ready` = 0, `conv_result` = 0 and `dac_trial` = 0. Release passes through a two-stage synchronizer, so the first period advance happens on the third rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_n | input | 1 | Active-low start request |
| rdy_clear_n | input | 1 | Active-low clear for the ready flag |
| cmp_bit | input | 1 | Comparator decision, 1 when the input is at or above `dac_trial` |
| track_en | output | 1 | 1 = track, 0 = hold |
| dac_trial | output | 10 | Trial code for the DAC |
| conv_result | output | 10 | Last completed code |
| result_ready | output | 1 | New code available |

## Verification
The assertions check on every cycle that:
- the period counter steps and wraps, and that it waits or advances in period 2 according to the start request;
- the ready flag rises only as a frame begins, and that any clear removes it;
- the result holds still between frame boundaries.

Whether the converted codes are correct can only be shown by the bench's scenarios, which drive a comparator model over extreme and alternating codes. The same applies to how the ready flag depends on when start arrives: a pulse confined to period 1, a long wait, and a clear held across the frame boundary.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int DEF_RES_W   = 10;
  localparam int DEF_TRACK_P = 3;

  function automatic int frame_periods(input int res_w, input int track_p);
    return res_w + track_p;
  endfunction
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/sar_frame_ctr.sv
module sar_frame_ctr #(
  parameter int FRAME_LEN = 13,
  parameter int PER_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  output logic [PER_W-1:0] per_q
);
  localparam logic [PER_W-1:0] P_FIRST = PER_W'(1);
  localparam logic [PER_W-1:0] P_WAIT  = PER_W'(2);
  localparam logic [PER_W-1:0] P_LAST  = PER_W'(FRAME_LEN);

  logic             armed_q, armed_d;
  logic [PER_W-1:0] per_d;
  logic             adv;

  always_comb begin
    adv = 1'b1;
    if (per_q == P_WAIT && start_n && !armed_q) adv = 1'b0;
    per_d = per_q;
    if (adv) per_d = (per_q == P_LAST) ? P_FIRST : per_q + PER_W'(1);
    armed_d = (per_q == P_FIRST) && !start_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q   <= P_FIRST;
      armed_q <= 1'b0;
    end else begin
      per_q   <= per_d;
      armed_q <= armed_d;
    end
  end

  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    per_q == P_LAST |=> per_q == P_FIRST);
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != P_LAST && per_q != P_WAIT) |=> per_q == $past(per_q) + PER_W'(1));
  a_r7_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == P_WAIT && $past(per_q) == P_WAIT && start_n) |=> per_q == P_WAIT);
  a_r8_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == P_WAIT && !start_n) |=> per_q == PER_W'(3));
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int RES_W     = 10,
  parameter int TRACK_P   = 3,
  parameter int FRAME_LEN = 13,
  parameter int PER_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] per,
  input  logic             cmp,
  output logic [RES_W-1:0] dac,
  output logic [RES_W-1:0] result_q
);
  localparam logic [PER_W-1:0] P_LAST  = PER_W'(FRAME_LEN);
  localparam logic [PER_W-1:0] P_TRKND = PER_W'(TRACK_P);

  logic             hold;
  logic [RES_W-1:0] trial_mask;
  logic [RES_W-1:0] sar_q, sar_d, result_d;

  always_comb begin
    hold = per > P_TRKND;
    for (int i = 0; i < RES_W; i++) begin
      trial_mask[i] = hold && (per == PER_W'(FRAME_LEN - i));
    end
    dac = hold ? (sar_q | trial_mask) : '0;
    sar_d = sar_q;
    if (per == P_TRKND) sar_d = '0;
    else if (hold && cmp) sar_d = sar_q | trial_mask;
    result_d = result_q;
    if (per == P_LAST) result_d = sar_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q    <= '0;
      result_q <= '0;
    end else begin
      sar_q    <= sar_d;
      result_q <= result_d;
    end
  end

  a_r4_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    per != P_LAST |=> $stable(result_q));
  a_r3_one_trial: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> $countones(dac & ~sar_q) == 1);
  a_r3_track_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> dac == '0);
endmodule

// File: rtl/sar_ready_flag.sv
module sar_ready_flag #(
  parameter int FRAME_LEN = 13,
  parameter int PER_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] per,
  input  logic             start_n,
  input  logic             clear_n,
  output logic             rdy_q
);
  localparam logic [PER_W-1:0] P_FIRST = PER_W'(1);
  localparam logic [PER_W-1:0] P_WAIT  = PER_W'(2);
  localparam logic [PER_W-1:0] P_LAST  = PER_W'(FRAME_LEN);

  logic rdy_d;

  always_comb begin
    rdy_d = rdy_q;
    if (per == P_LAST) rdy_d = 1'b1;
    else if ((per == P_FIRST || per == P_WAIT) && !start_n) rdy_d = 1'b0;
    if (!clear_n) rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> !rdy_q);
  a_r5_rise_at_p1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> per == P_FIRST);
  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    (per == P_LAST && clear_n) |=> rdy_q);
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int RES_W   = sar_seq_pkg::DEF_RES_W,
  parameter int TRACK_P = sar_seq_pkg::DEF_TRACK_P
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start_n,
  input  logic             rdy_clear_n,
  input  logic             cmp_bit,
  output logic             track_en,
  output logic [RES_W-1:0] dac_trial,
  output logic [RES_W-1:0] conv_result,
  output logic             result_ready
);
  localparam int FRAME_LEN = sar_seq_pkg::frame_periods(RES_W, TRACK_P);
  localparam int PER_W     = $clog2(FRAME_LEN + 1);

  logic             rst_int_n;
  logic [PER_W-1:0] per;

  sar_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sar_frame_ctr #(.FRAME_LEN(FRAME_LEN), .PER_W(PER_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_n (conv_start_n),
    .per_q   (per)
  );

  sar_bit_engine #(.RES_W(RES_W), .TRACK_P(TRACK_P), .FRAME_LEN(FRAME_LEN), .PER_W(PER_W)) u_sar (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .per      (per),
    .cmp      (cmp_bit),
    .dac      (dac_trial),
    .result_q (conv_result)
  );

  sar_ready_flag #(.FRAME_LEN(FRAME_LEN), .PER_W(PER_W)) u_rdy (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .per     (per),
    .start_n (conv_start_n),
    .clear_n (rdy_clear_n),
    .rdy_q   (result_ready)
  );

  assign track_en = (per <= PER_W'(TRACK_P));

  a_r2_hold_start: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(track_en) |-> per == PER_W'(TRACK_P + 1));
  a_r2_track_start: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(track_en) |-> per == PER_W'(1));
endmodule

// File: tb/sar_conv_seq_bench.sv
module sar_conv_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n, conv_start_n, rdy_clear_n;
  logic       track_en, result_ready;
  logic [9:0] dac_trial, conv_result, ana_level;
  logic       cmp_bit;

  int checks = 0, errors = 0;
  int exp_q[$];
  bit sb_en = 1'b0, have_rise = 1'b0;
  int cyc = 0;
  logic trk_prev = 1'b0, rdy_prev = 1'b0;
  logic [9:0] last_res = '0;

  always #2 clk = ~clk;

  assign cmp_bit = (ana_level >= dac_trial);

  sar_conv_seq u_sar_conv_seq (
    .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n), .rdy_clear_n(rdy_clear_n),
    .cmp_bit(cmp_bit), .track_en(track_en), .dac_trial(dac_trial),
    .conv_result(conv_result), .result_ready(result_ready));

  always @(posedge clk) begin
    trk_prev <= track_en;
    rdy_prev <= result_ready;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_frame();
    do @(negedge clk); while (!(track_en && !trk_prev));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb_en) begin
      if (result_ready && !rdy_prev) begin
        int e;
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected result", conv_result, 0);
        else begin
          e = exp_q.pop_front();
          chk(conv_result == 10'(e), "R3/R4 result", conv_result, e);
        end
        if (have_rise) chk(cyc == 13, "R1 frame length", cyc, 13);
        have_rise = 1'b1;
        cyc = 1;
        last_res = conv_result;
      end else if (have_rise) begin
        chk(track_en == (cyc < 3), "R2 track window", track_en, (cyc < 3));
        chk(conv_result == last_res, "R4 result stable", conv_result, last_res);
        cyc++;
      end
    end
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int codes[6] = '{0, 1023, 512, 511, 'h155, 'h2AA};
    rst_n = 1'b0; conv_start_n = 1'b0; rdy_clear_n = 1'b1; ana_level = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(track_en == 1'b1, "R11 track in reset", track_en, 1);
    chk(result_ready == 1'b0, "R11 ready in reset", result_ready, 0);
    chk(conv_result == 10'd0, "R11 result in reset", conv_result, 0);
    chk(dac_trial == 10'd0, "R11 dac in reset", dac_trial, 0);
    sb_en = 1'b1;
    ana_level = 10'(codes[0]);
    exp_q.push_back(codes[0]);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(track_en == 1'b1, "R11 sync release", track_en, 1);
    @(negedge clk);
    chk(track_en == 1'b0, "R11/R2 first hold", track_en, 0);
    chk(dac_trial == 10'h200, "R3 msb trial", dac_trial, 'h200);
    for (int i = 1; i < 6; i++) begin
      wait_frame();
      ana_level = 10'(codes[i]);
      exp_q.push_back(codes[i]);
    end
    wait_frame();
    @(negedge clk);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    sb_en = 1'b0;

    // R7 wait in period 2
    while (track_en) @(negedge clk);
    conv_start_n = 1'b1;
    wait_frame();
    chk(result_ready == 1'b1, "R5 ready at period 1", result_ready, 1);
    chk(conv_result == 10'h2AA, "R4 result 0x2AA", conv_result, 'h2AA);
    @(negedge clk);
    chk(result_ready == 1'b1, "R7 ready kept in period 2", result_ready, 1);
    repeat (10) @(negedge clk);
    chk(result_ready == 1'b1, "R7 ready during wait", result_ready, 1);
    chk(track_en == 1'b1, "R7 tracking during wait", track_en, 1);
    // R9 clear while waiting
    rdy_clear_n = 1'b0;
    @(negedge clk);
    chk(result_ready == 1'b0, "R9 clear drops ready", result_ready, 0);
    rdy_clear_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(track_en == 1'b1, "R7 still waiting", track_en, 1);
    // R8 resume
    conv_start_n = 1'b0;
    @(negedge clk);
    conv_start_n = 1'b1;
    chk(track_en == 1'b1, "R8 period 3 track", track_en, 1);
    chk(result_ready == 1'b0, "R8 ready low", result_ready, 0);
    @(negedge clk);
    chk(track_en == 1'b0, "R8 hold after resume", track_en, 0);
    chk(dac_trial == 10'h200, "R3 first trial after resume", dac_trial, 'h200);
    // R6 start pulse confined to period 1
    wait_frame();
    chk(result_ready == 1'b1, "R5 ready rises", result_ready, 1);
    conv_start_n = 1'b0;
    @(negedge clk);
    conv_start_n = 1'b1;
    chk(result_ready == 1'b0, "R6 ready falls at period 2", result_ready, 0);
    @(negedge clk);
    chk(track_en == 1'b1, "R6 period 3", track_en, 1);
    @(negedge clk);
    chk(track_en == 1'b0, "R6 no wait", track_en, 0);
    // R10 clear held across frame boundary
    rdy_clear_n = 1'b0;
    ana_level = 10'h155;
    wait_frame();
    chk(result_ready == 1'b0, "R10 ready suppressed", result_ready, 0);
    chk(conv_result == 10'h155, "R10 result still updated", conv_result, 'h155);
    rdy_clear_n = 1'b1;
    @(negedge clk);
    chk(result_ready == 1'b0, "R10 no late rise", result_ready, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule